// File: doc/BRIEF.md
# Variable-Length Parcel Fetch Sequencer

This block is the control sequencer of a small nibble-wide machine. It holds an 8-bit program counter, fetches 4-bit parcels from a 256-entry word memory over a synchronous read/write port, and works out each instruction's length as the parcels arrive. An instruction is one, two or three parcels long. Arithmetic instructions and register transfers are handed to an execution unit through a one-cycle strobe that carries an opcode and an operand nibble.

The sequencer carries out memory loads, memory stores and the conditional branch itself. For these it builds an 8-bit address from two trailing parcels. A load strobes the execution unit with the word that was read. A store writes the accumulator value supplied by the execution unit. A branch reloads the program counter when the accumulator's sign bit is set.

Top module: `parcel_seq`

## Requirements
- R1: While reset is high, and at the first cycle after reset, the program counter is 0, the strobe is low and write enable is low. The first fetch after reset reads address 0.
- R2: A first parcel whose two top bits are not `11` is a whole instruction. In the cycle after its fetch the strobe is high for exactly one cycle, the opcode equals that parcel and the operand is 0. Back-to-back one-parcel instructions strobe every 2 cycles.
- R3: A first parcel of `1100` (transfer) fetches one more parcel. The strobe then carries opcode `1100`, and the operand equals the second parcel. The strobe comes 4 cycles after the previous instruction's strobe when the two follow each other.
- R4: For first parcels `1101`, `1110` and `1111`, two more parcels are fetched. The earlier one forms bits 7:4 of the target address and the later one forms bits 3:0.
- R5: `1101` (load) reads memory at the target address. A strobe with opcode `1101` and operand equal to the word read follows, 8 cycles after the previous strobe when the two follow each other.
- R6: `1110` (store) writes `acc_val` to memory at the target address for one cycle, gives no strobe, and leaves other addresses unchanged.
- R7: `1111` (branch) gives no strobe. When `acc_val[3]` is 1, the next fetch is from the target address. When it is 0, fetching continues at the parcel after the address parcels.
- R8: The program counter advances by one for every parcel fetched and wraps from 255 to 0.
- R9: Write enable is never high in two consecutive cycles and never high together with the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory address for parcel fetch, load or store |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 4 | Memory write data (accumulator value) |
| mem_rdata | input | 4 | Memory read data, valid one cycle after the address |
| acc_val | input | 4 | Current accumulator value from the execution unit |
| ex_valid | output | 1 | One-cycle strobe to the execution unit |
| ex_opcode | output | 4 | Opcode presented with the strobe |
| ex_operand | output | 4 | Transfer field or loaded word; 0 for arithmetic |
| prog_ctr | output | 8 | Current program counter |

## Verification
The bench uses the default widths: 4-bit parcels and an 8-bit counter over the full 256-word space. This lets a branch aimed at address 255 show the counter wrapping to 0. A load from 0x30, where the word at 0x03 differs, shows the order of the address nibbles. Accumulator values 7 and 8 lie on either side of the sign-bit test that decides the branch. Strobe spacing in cycles is measured to confirm the fetch cost of each instruction length.

// File: rtl/parcel_seq_pkg.sv
package parcel_seq_pkg;
    localparam int WORD_W = 4;
    localparam int PC_W   = 2 * WORD_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PC_W-1:0]   addr_t;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_CAPT,
        ST_EXEC,
        ST_LDW
    } st_t;

    localparam word_t OP_XFER = 4'hC;
    localparam word_t OP_LOAD = 4'hD;
    localparam word_t OP_STOR = 4'hE;
    localparam word_t OP_BRN  = 4'hF;

    typedef struct packed {
        word_t op;
        word_t hi;
        word_t lo;
    } instr_t;

    function automatic logic is_single(word_t p);
        return p[WORD_W-1 -: 2] != 2'b11;
    endfunction
endpackage

// File: rtl/parcel_seq_pc.sv
module parcel_seq_pc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] target,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= target;
        else if (inc)  q <= q + 1'b1;
    end

    a_r1_reset_state: assert property (@(posedge clk) $past(rst) |-> q == '0);

    a_r8_pc_step: assert property (@(posedge clk) disable iff (rst)
        ($past(inc) && !$past(load) && !$past(rst)) |-> q == $past(q) + 1'b1);
endmodule

// File: rtl/parcel_seq_asm.sv
module parcel_seq_asm
    import parcel_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cap_en,
    input  logic [1:0] slot,
    input  word_t      parcel,
    output instr_t     ins
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ins <= '0;
        end else if (cap_en) begin
            case (slot)
                2'd0:    ins.op <= parcel;
                2'd1:    ins.hi <= parcel;
                default: ins.lo <= parcel;
            endcase
        end
    end
endmodule

// File: rtl/parcel_seq.sv
module parcel_seq
    import parcel_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [PC_W-1:0]   mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [WORD_W-1:0] acc_val,
    output logic              ex_valid,
    output logic [WORD_W-1:0] ex_opcode,
    output logic [WORD_W-1:0] ex_operand,
    output logic [PC_W-1:0]   prog_ctr
);
    st_t        st;
    logic [1:0] slot;
    instr_t     ins;
    addr_t      target;
    logic       pc_inc, pc_load, cap_en;

    parcel_seq_pc #(.W(PC_W)) u_pc (
        .clk(clk), .rst(rst), .inc(pc_inc), .load(pc_load),
        .target(target), .q(prog_ctr)
    );

    parcel_seq_asm u_asm (
        .clk(clk), .rst(rst), .cap_en(cap_en), .slot(slot),
        .parcel(mem_rdata), .ins(ins)
    );

    always_comb begin
        target    = {ins.hi, ins.lo};
        pc_inc    = (st == ST_FETCH);
        cap_en    = (st == ST_CAPT);
        mem_addr  = (st == ST_EXEC) ? target : prog_ctr;
        mem_we    = (st == ST_EXEC) && (ins.op == OP_STOR);
        mem_wdata = acc_val;
        pc_load   = (st == ST_EXEC) && (ins.op == OP_BRN) && acc_val[WORD_W-1];
    end

    always_comb begin
        ex_valid   = 1'b0;
        ex_opcode  = '0;
        ex_operand = '0;
        if (st == ST_CAPT && slot == 2'd0 && is_single(mem_rdata)) begin
            ex_valid  = 1'b1;
            ex_opcode = mem_rdata;
        end else if (st == ST_CAPT && slot == 2'd1 && ins.op == OP_XFER) begin
            ex_valid   = 1'b1;
            ex_opcode  = OP_XFER;
            ex_operand = mem_rdata;
        end else if (st == ST_LDW) begin
            ex_valid   = 1'b1;
            ex_opcode  = OP_LOAD;
            ex_operand = mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_FETCH;
            slot <= 2'd0;
        end else begin
            case (st)
                ST_FETCH: st <= ST_CAPT;
                ST_CAPT: begin
                    st <= ST_FETCH;
                    case (slot)
                        2'd0:    slot <= is_single(mem_rdata) ? 2'd0 : 2'd1;
                        2'd1:    slot <= (ins.op == OP_XFER) ? 2'd0 : 2'd2;
                        default: begin
                            slot <= 2'd0;
                            st   <= ST_EXEC;
                        end
                    endcase
                end
                ST_EXEC: st <= (ins.op == OP_LOAD) ? ST_LDW : ST_FETCH;
                default: st <= ST_FETCH;
            endcase
        end
    end

    // R2: strobe lasts one cycle; arithmetic carries a zero operand
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
        ex_valid |=> !ex_valid);
    a_r2_arith_operand: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && is_single(ex_opcode)) |-> ex_operand == '0);
    // R7: a taken branch lands on the assembled target
    a_r7_branch_target: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> prog_ctr == $past(target));
    // R9: writes are isolated single cycles
    a_r9_write_single: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);
    a_r9_write_no_strobe: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !ex_valid);
endmodule

// File: tb/parcel_seq_bench.sv
module parcel_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_addr;
    logic       mem_we;
    logic [3:0] mem_wdata;
    logic [3:0] mem_rdata;
    logic [3:0] acc_val = 4'h0;
    logic       ex_valid;
    logic [3:0] ex_opcode, ex_operand;
    logic [7:0] prog_ctr;

    always #(CLK_PERIOD/2) clk = ~clk;

    parcel_seq u_parcel_seq (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .acc_val(acc_val),
        .ex_valid(ex_valid), .ex_opcode(ex_opcode), .ex_operand(ex_operand),
        .prog_ctr(prog_ctr)
    );

    logic [3:0] mem [256];
    always @(posedge clk) begin
        if (mem_we === 1'b1) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int         ev_n;
    logic [3:0] ev_op  [16];
    logic [3:0] ev_opd [16];
    logic [7:0] ev_pc  [16];
    int         ev_cyc [16];
    always @(negedge clk) begin
        if (rst) ev_n <= 0;
        else if (ex_valid && ev_n < 16) begin
            ev_op[ev_n]  <= ex_opcode;
            ev_opd[ev_n] <= ex_operand;
            ev_pc[ev_n]  <= prog_ctr;
            ev_cyc[ev_n] <= cyc;
            ev_n         <= ev_n + 1;
        end
    end

    // {opcode, operand, program counter at strobe}
    localparam logic [15:0] EXP [10] = '{
        {4'h1, 4'h0, 8'd1},  {4'h5, 4'h0, 8'd2},  {4'h8, 4'h0, 8'd3},
        {4'hB, 4'h0, 8'd4},  {4'hC, 4'h9, 8'd6},  {4'hD, 4'h2, 8'd9},
        {4'h6, 4'h0, 8'd16}, {4'hA, 4'h0, 8'd17}, {4'h0, 4'h0, 8'd18},
        {4'h0, 4'h0, 8'd19}
    };

    int errors = 0;
    int checks = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 4'h0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_events(input int n, input string tag);
        int t = 0;
        while (ev_n < n && t < 400) begin
            @(negedge clk);
            t++;
        end
        #1;
        if (ev_n < n) begin
            checks++;
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d strobes (timeout)", tag, ev_n, n);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Run 1: mixed program, acc = 7 (branch not taken)
        clear_mem();
        mem[0] = 4'h1;  mem[1] = 4'h5;  mem[2] = 4'h8;  mem[3] = 4'hB;
        mem[4] = 4'hC;  mem[5] = 4'h9;
        mem[6] = 4'hD;  mem[7] = 4'h3;  mem[8] = 4'h0;
        mem[9] = 4'hE;  mem[10] = 4'h3; mem[11] = 4'h1;
        mem[12] = 4'hF; mem[13] = 4'h4; mem[14] = 4'h0;
        mem[15] = 4'h6; mem[16] = 4'hA;
        mem[8'h30] = 4'h2;
        acc_val = 4'h7;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 pc in reset", prog_ctr, 0);
        check("R1 strobe in reset", ex_valid, 0);
        check("R1 write in reset", mem_we, 0);
        rst = 1'b0;
        #1;
        check("R1 first fetch address", mem_addr, 0);
        wait_events(10, "R2 run1");
        for (int i = 0; i < 10; i++) begin
            string tg;
            tg = (EXP[i][15:12] == 4'hC) ? "R3 transfer" :
                 (EXP[i][15:12] == 4'hD) ? "R5 load" : "R2 single";
            check({tg, " opcode"}, ev_op[i], EXP[i][15:12]);
            check({tg, " operand"}, ev_opd[i], EXP[i][11:8]);
            check("R8 pc at strobe", ev_pc[i], EXP[i][7:0]);
        end
        check("R2 single spacing", ev_cyc[1] - ev_cyc[0], 2);
        check("R3 transfer spacing", ev_cyc[4] - ev_cyc[3], 4);
        check("R5 load spacing", ev_cyc[5] - ev_cyc[4], 8);
        check("R4 high nibble first (load of 0x30)", ev_opd[5], 2);
        check("R7 not taken continues at 15", ev_pc[6], 16);
        check("R6 store wrote acc to 0x31", mem[8'h31], 7);
        check("R6 neighbour 0x30 unchanged", mem[8'h30], 2);
        check("R6 no strobe from store/branch", ev_op[6], 6);

        // Run 2: branch taken with acc = 8
        clear_mem();
        mem[0] = 4'hF; mem[1] = 4'h2; mem[2] = 4'h0;
        mem[8'h20] = 4'h5;
        acc_val = 4'h8;
        do_reset();
        wait_events(1, "R7 taken");
        check("R7 taken opcode", ev_op[0], 5);
        check("R7 taken pc", ev_pc[0], 8'h21);

        // Run 3: branch to 255, counter wraps to 0
        clear_mem();
        mem[0] = 4'hF; mem[1] = 4'hF; mem[2] = 4'hF;
        mem[255] = 4'h1;
        do_reset();
        wait_events(2, "R8 wrap");
        check("R8 wrap opcode", ev_op[0], 1);
        check("R8 wrap pc", ev_pc[0], 0);
        check("R8 wrap repeat pc", ev_pc[1], 0);
        check("R7 loop spacing", ev_cyc[1] - ev_cyc[0], 9);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule